// File: doc/BRIEF.md
# ADC Scan Pattern Sequencer

This block is the digital sequencer that sits in front of two successive-approximation converters. An interval timer produces measurement triggers. On each trigger the sequencer looks up the next rule in a per-unit rule table and raises a conversion request. The request carries the channel, attenuation and resolution codes of that rule. Results that come back are packed into 16-bit words and streamed out with a valid strobe. A frame-end flag marks every Nth word.

Software sets everything up through a small register-style write port. The settings are the sampling mode, the output word layout, the trigger interval, an optional stop limit, the frame length, the two table lengths and the table entries. A start pulse arms the sequencer and a stop pulse disarms it. The block runs on the divided converter clock. It handles one outstanding request per unit; a trigger that finds its unit still busy is dropped and recorded.

Top module: `adc_scan_seq`

## Requirements
- R1: A table entry is one byte: attenuation in bits [1:0], resolution code in bits [3:2] (0 = 9-bit up to 3 = 12-bit), channel in bits [7:4]. When a request is issued, conv_chan, conv_atten and conv_res carry these fields for that unit, and they stay unchanged until its conv_done.
- R2: Each unit walks its entries in order from entry 0 and wraps to 0 after entry length-1. Length is written at address 4 (unit 1) or 5 (unit 2). Values above 16 are treated as 16. Writing 0 leaves the previous length. Entries are written at address 16+i (unit 1) and 32+i (unit 2).
- R3: The mode is set by bits [2:0] of address 0. Code 1 requests only unit 1. Code 2 requests only unit 2. Code 3 requests both units on the same trigger. Code 7 alternates units on successive triggers, starting with unit 1. Any other code issues nothing.
- R4: Triggers come every 2 x interval clock cycles; the interval is written at address 1. Values below 40 act as 40.
- R5: When bit 3 of address 0 is 0, a result is output as channel in [15:12] and the 12-bit result in [11:0].
- R6: When bit 3 of address 0 is 1, the word is the unit in bit 15 (0 = unit 1), the channel in [14:11] and the upper 11 result bits in [10:0].
- R7: When bit 4 of address 0 is set, triggering stops after as many issued triggers as the limit at address 2 (1 to 255).
- R8: out_eof is raised with every word that brings the count of words since start to a multiple of the frame count at address 3 (0 = never). Mode 3 yields two words per trigger.
- R9: A trigger whose unit still has a request outstanding is dropped and sets the sticky overrun output.
- R10: start rewinds the table pointers and the counters and clears overrun. stop halts triggering, but a request already in flight still completes and its word is still output.
- R11: After reset no request, no output word and no overrun are present.
- R12: When both units finish in the same cycle, the unit 1 word is output first and the unit 2 word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Arm pulse: rewind pointers and counters |
| stop | input | 1 | Disarm pulse |
| conv_req | output | 2 | Per-unit request, high until conv_done |
| conv_chan | output | 8 | Channel per unit, 4 bits each |
| conv_atten | output | 4 | Attenuation per unit, 2 bits each |
| conv_res | output | 4 | Resolution code per unit, 2 bits each |
| conv_done | input | 2 | Per-unit result strobe |
| conv_data | input | 24 | Per-unit 12-bit result |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Packed output word |
| out_eof | output | 1 | Frame-end flag with the word |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
Each mode is run with tables filled with distinct entries, so every request and every returned word can be matched to its table slot. The table lengths are short, full, or rewritten with 0, which separates correct wrapping from off-by-one wrapping. Intervals under, at and above the floor show the clamp. Both-unit mode with equal converter latency forces simultaneous results and shows the output ordering. A converter that never answers, a stop during a conversion, a small trigger limit and an unused mode code each isolate one of the stopping and dropping rules.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef struct packed {
    logic [3:0] chan;
    logic [1:0] res;
    logic [1:0] atten;
  } scan_entry_t;

  localparam logic [2:0] MODE_U1   = 3'd1;
  localparam logic [2:0] MODE_U2   = 3'd2;
  localparam logic [2:0] MODE_BOTH = 3'd3;
  localparam logic [2:0] MODE_ALT  = 3'd7;

  localparam int REG_CTRL = 0;
  localparam int REG_IVL  = 1;
  localparam int REG_LIM  = 2;
  localparam int REG_FRM  = 3;
  localparam int REG_LEN0 = 4;
  localparam int REG_LEN1 = 5;

endpackage

// File: rtl/adc_trig_timer.sv
module adc_trig_timer #(
  parameter int IVL_W   = 12,
  parameter int IVL_MIN = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [IVL_W-1:0] ivl,
  output logic             trig
);
  logic [IVL_W:0] cnt_q;
  logic [IVL_W:0] last;

  always_comb begin
    if (ivl < IVL_W'(IVL_MIN)) last = {IVL_W'(IVL_MIN), 1'b0} - 1'b1;
    else                       last = {ivl, 1'b0} - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
      trig  <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
      trig  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      trig  <= 1'b0;
    end
  end

  // R4: the period is at least 80 cycles, so pulses never touch
  assert_trig_gap_R4: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

endmodule

// File: rtl/adc_pattern_tbl.sv
module adc_pattern_tbl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int TBL_AW = 4,
  parameter int LEN_W  = TBL_AW + 1,
  parameter int LIM_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         stop,
  input  logic                         trig,
  input  logic [2:0]                   mode,
  input  logic                         lim_en,
  input  logic [LIM_W-1:0]             lim,
  input  logic [1:0][LEN_W-1:0]        len,
  input  logic [1:0][7:0]              ent,
  input  logic [1:0]                   done,
  output logic [1:0][TBL_AW-1:0]       ptr_q,
  output logic [1:0]                   req_q,
  output scan_entry_t [1:0]            req_ent_q,
  output logic                         run_q,
  output logic                         ovr_q
);
  logic [1:0]       want;
  logic             alt_q;
  logic [LIM_W-1:0] tcnt_q;
  logic             fire;
  logic             issue;

  always_comb begin
    case (mode)
      MODE_U1:   want = 2'b01;
      MODE_U2:   want = 2'b10;
      MODE_BOTH: want = 2'b11;
      MODE_ALT:  want = alt_q ? 2'b10 : 2'b01;
      default:   want = 2'b00;
    endcase
    fire  = trig && run_q && (want != 2'b00) && !start;
    issue = fire && ((want & req_q) == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      req_ent_q <= '0;
      ptr_q     <= '0;
      run_q     <= 1'b0;
      alt_q     <= 1'b0;
      tcnt_q    <= '0;
      ovr_q     <= 1'b0;
    end else begin
      for (int u = 0; u < 2; u++) begin
        if (issue && want[u]) begin
          req_q[u]     <= 1'b1;
          req_ent_q[u] <= ent[u];
          ptr_q[u]     <= ({1'b0, ptr_q[u]} >= len[u] - 1'b1) ? '0 : ptr_q[u] + 1'b1;
        end else if (done[u]) begin
          req_q[u] <= 1'b0;
        end
      end
      if (start) begin
        run_q  <= 1'b1;
        ptr_q  <= '0;
        alt_q  <= 1'b0;
        tcnt_q <= '0;
        ovr_q  <= 1'b0;
      end else begin
        if (stop) run_q <= 1'b0;
        if (issue) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (mode == MODE_ALT) alt_q <= ~alt_q;
          if (lim_en && (tcnt_q + 1'b1 == lim)) run_q <= 1'b0;
        end
        if (fire && !issue) ovr_q <= 1'b1;
      end
    end
  end

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovr_q && !start |=> ovr_q);

  for (genvar u = 0; u < 2; u++) begin : g_chk
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
      req_q[u] && !done[u] |=> req_q[u]);
    assert_fields_stable_R1: assert property (@(posedge clk) disable iff (rst)
      req_q[u] && !done[u] |=> $stable(req_ent_q[u]));
    assert_req_after_trig_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(req_q[u]) |-> $past(trig));
  end

endmodule

// File: rtl/adc_out_pack.sv
module adc_out_pack #(
  parameter int DATA_W = 12,
  parameter int FRM_W  = 12,
  parameter int OUT_W  = 4 + DATA_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   fmt,
  input  logic [FRM_W-1:0]       frm,
  input  logic [1:0]             done,
  input  logic [1:0][DATA_W-1:0] data,
  input  logic [1:0][3:0]        chan,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_data,
  output logic                   out_eof
);
  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  logic [3:0]        hold_c;
  logic [FRM_W-1:0]  cnt_q;
  logic              emit_v;
  logic              emit_u;
  logic [3:0]        emit_c;
  logic [DATA_W-1:0] emit_d;
  logic              wrap;

  function automatic logic [OUT_W-1:0] pack(input logic f, input logic u,
                                            input logic [3:0] c,
                                            input logic [DATA_W-1:0] d);
    if (f) return {u, c, d[DATA_W-1:1]};
    return {c, d};
  endfunction

  always_comb begin
    emit_v = done[0] || hold_v || done[1];
    if (done[0]) begin
      emit_u = 1'b0; emit_c = chan[0]; emit_d = data[0];
    end else if (hold_v) begin
      emit_u = 1'b1; emit_c = hold_c;  emit_d = hold_d;
    end else begin
      emit_u = 1'b1; emit_c = chan[1]; emit_d = data[1];
    end
    wrap = (frm != '0) && (cnt_q + 1'b1 == frm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_d    <= '0;
      hold_c    <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= emit_v;
      out_data  <= pack(fmt, emit_u, emit_c, emit_d);
      out_eof   <= emit_v && wrap;
      if (start)       cnt_q <= '0;
      else if (emit_v) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (done[1] && (done[0] || hold_v)) begin
        hold_v <= 1'b1;
        hold_d <= data[1];
        hold_c <= chan[1];
      end else if (!done[0] && hold_v) begin
        hold_v <= 1'b0;
      end
    end
  end

  assert_eof_with_word_R8: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);
  assert_second_parked_R12: assert property (@(posedge clk) disable iff (rst)
    done[0] && done[1] |=> hold_v && out_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int TBL_DEPTH = 16,
  parameter int IVL_W     = 12,
  parameter int IVL_MIN   = 40,
  parameter int LIM_W     = 8,
  parameter int FRM_W     = 12,
  parameter int CFG_DW    = 16,
  parameter int CFG_AW    = $clog2(TBL_DEPTH) + 2,
  parameter int OUT_W     = 4 + DATA_W
) (
  input  logic                rst,
  input  logic                clk,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic                start,
  input  logic                stop,
  output logic [1:0]          conv_req,
  output logic [7:0]          conv_chan,
  output logic [3:0]          conv_atten,
  output logic [3:0]          conv_res,
  input  logic [1:0]          conv_done,
  input  logic [2*DATA_W-1:0] conv_data,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_eof,
  output logic                overrun
);
  localparam int TBL_AW = $clog2(TBL_DEPTH);
  localparam int LEN_W  = TBL_AW + 1;

  logic [2:0]             mode_q;
  logic                   fmt_q;
  logic                   lim_en_q;
  logic [IVL_W-1:0]       ivl_q;
  logic [LIM_W-1:0]       lim_q;
  logic [FRM_W-1:0]       frm_q;
  logic [1:0][LEN_W-1:0]  len_q;

  logic [1:0]             region;
  logic [TBL_AW-1:0]      idx;
  logic [1:0][TBL_AW-1:0] ptr;
  logic [1:0][7:0]        ent;
  scan_entry_t [1:0]      req_ent;
  logic [1:0][3:0]        req_chan;
  logic [1:0][DATA_W-1:0] data_u;
  logic                   trig;
  logic                   run;

  assign region = cfg_addr[CFG_AW-1:TBL_AW];
  assign idx    = cfg_addr[TBL_AW-1:0];
  assign data_u = conv_data;

  function automatic logic [LEN_W-1:0] fit_len(input logic [CFG_DW-1:0] w);
    if (w > CFG_DW'(TBL_DEPTH)) return LEN_W'(TBL_DEPTH);
    return w[LEN_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_U1;
      fmt_q    <= 1'b0;
      lim_en_q <= 1'b0;
      ivl_q    <= IVL_W'(IVL_MIN);
      lim_q    <= LIM_W'(1);
      frm_q    <= '0;
      len_q    <= {LEN_W'(1), LEN_W'(1)};
    end else if (cfg_we && region == 2'd0) begin
      case (int'(idx))
        REG_CTRL: begin
          mode_q   <= cfg_wdata[2:0];
          fmt_q    <= cfg_wdata[3];
          lim_en_q <= cfg_wdata[4];
        end
        REG_IVL:  ivl_q <= cfg_wdata[IVL_W-1:0];
        REG_LIM:  lim_q <= cfg_wdata[LIM_W-1:0];
        REG_FRM:  frm_q <= cfg_wdata[FRM_W-1:0];
        REG_LEN0: if (cfg_wdata != '0) len_q[0] <= fit_len(cfg_wdata);
        REG_LEN1: if (cfg_wdata != '0) len_q[1] <= fit_len(cfg_wdata);
        default: ;
      endcase
    end
  end

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic we_u;
    assign we_u = cfg_we && (region == 2'(u + 1));

    adc_pattern_tbl #(.DEPTH(TBL_DEPTH), .AW(TBL_AW)) i_tbl (
      .clk   (clk),
      .we    (we_u),
      .waddr (idx),
      .wdata (cfg_wdata[7:0]),
      .raddr (ptr[u]),
      .rdata (ent[u])
    );

    assign req_chan[u]          = req_ent[u].chan;
    assign conv_chan[4*u +: 4]  = req_ent[u].chan;
    assign conv_atten[2*u +: 2] = req_ent[u].atten;
    assign conv_res[2*u +: 2]   = req_ent[u].res;

    assert_len_range_R2: assert property (@(posedge clk) disable iff (rst)
      len_q[u] != '0 && len_q[u] <= LEN_W'(TBL_DEPTH));
  end

  adc_trig_timer #(.IVL_W(IVL_W), .IVL_MIN(IVL_MIN)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (start),
    .ivl     (ivl_q),
    .trig    (trig)
  );

  adc_scan_ctrl #(.TBL_AW(TBL_AW), .LEN_W(LEN_W), .LIM_W(LIM_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .trig      (trig),
    .mode      (mode_q),
    .lim_en    (lim_en_q),
    .lim       (lim_q),
    .len       (len_q),
    .ent       (ent),
    .done      (conv_done),
    .ptr_q     (ptr),
    .req_q     (conv_req),
    .req_ent_q (req_ent),
    .run_q     (run),
    .ovr_q     (overrun)
  );

  adc_out_pack #(.DATA_W(DATA_W), .FRM_W(FRM_W), .OUT_W(OUT_W)) i_pack (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fmt       (fmt_q),
    .frm       (frm_q),
    .done      (conv_done),
    .data      (data_u),
    .chan      (req_chan),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eof   (out_eof)
  );

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int DW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [1:0]  conv_req;
  logic [7:0]  conv_chan;
  logic [3:0]  conv_atten;
  logic [3:0]  conv_res;
  logic [1:0]  conv_done = '0;
  logic [23:0] conv_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_eof;
  logic        overrun;

  always #2 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .rst(rst), .clk(clk), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .stop(stop),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_atten(conv_atten),
    .conv_res(conv_res), .conv_done(conv_done), .conv_data(conv_data),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .overrun(overrun)
  );

  int checks = 0, errors = 0;
  bit fin = 0;

  logic [7:0]  tbl_m [2][16];
  int          blen [2];
  int          bptr [2];
  bit          pend [2];
  int          cd [2];
  logic [2:0]  bmode;
  bit          bfmt;
  int          bfrm, bspace, last_u, lat, serial, wcnt, nreq, nwords;
  bit          hang, first_after_start;
  longint      cyc = 0, last_rise = -1;
  logic [15:0] expq [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [DW-1:0] d;
    logic [7:0]    e;
    logic [15:0]   w;
    bit            ee;
    cyc++;
    if (rst) begin
      conv_done = '0;
      pend[0] = 0; pend[1] = 0;
    end else begin
      if (out_valid) begin
        if (expq.size() == 0) chk(0, "R5 unexpected word", out_data, 0);
        else begin
          w = expq.pop_front();
          chk(out_data == w, bmode == 3'd3 ? "R12 order of both-unit words" :
              (bfmt ? "R6 11-bit word" : "R5 12-bit word"), out_data, w);
          ee = (bfrm != 0) && (((wcnt + 1) % bfrm) == 0);
          chk(out_eof == ee, "R8 frame end", out_eof, ee);
          wcnt++; nwords++;
        end
      end
      for (int u = 0; u < 2; u++) begin
        conv_done[u] = 1'b0;
        if (pend[u]) begin
          if (!hang) begin
            if (cd[u] == 0) begin
              d = DW'((serial * 229 + 7 * u + 3) % 4096);
              serial++;
              conv_data[u*DW +: DW] = d;
              conv_done[u] = 1'b1;
              pend[u] = 0;
              if (bfmt) expq.push_back({1'(u), conv_chan[u*4 +: 4], d[11:1]});
              else      expq.push_back({conv_chan[u*4 +: 4], d});
            end else cd[u]--;
          end
        end else if (conv_req[u]) begin
          pend[u] = 1; cd[u] = lat; nreq++;
          e = tbl_m[u][bptr[u]];
          chk(conv_chan[u*4 +: 4] == e[7:4], "R1 channel field", conv_chan[u*4 +: 4], e[7:4]);
          chk(conv_res[u*2 +: 2] == e[3:2], "R1 resolution field", conv_res[u*2 +: 2], e[3:2]);
          chk(conv_atten[u*2 +: 2] == e[1:0], "R2 entry order (attenuation)", conv_atten[u*2 +: 2], e[1:0]);
          if (first_after_start) begin
            chk(conv_chan[u*4 +: 4] == tbl_m[u][0][7:4], "R10 restart at entry 0",
                conv_chan[u*4 +: 4], tbl_m[u][0][7:4]);
            first_after_start = 0;
          end
          bptr[u] = (bptr[u] + 1) % blen[u];
          case (bmode)
            3'd1: chk(u == 0, "R3 unit-1 mode", u, 0);
            3'd2: chk(u == 1, "R3 unit-2 mode", u, 1);
            3'd3: chk(conv_req == 2'b11, "R3 both-unit mode", conv_req, 3);
            3'd7: chk(u != last_u, "R3 alternating mode", u, 1 - last_u);
            default: chk(0, "R3 unused mode code", u, 0);
          endcase
          last_u = u;
          if (cyc != last_rise) begin
            if (last_rise >= 0) chk(cyc - last_rise == bspace, "R4 trigger spacing", cyc - last_rise, bspace);
            last_rise = cyc;
          end
        end
      end
    end
  end

  task automatic cfg_wr(input int a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int mode, input int fmt, input int limen, input int ivl,
                       input int lim, input int frm, input int l0, input int l1);
    cfg_wr(0, mode | (fmt << 3) | (limen << 4));
    cfg_wr(1, ivl); cfg_wr(2, lim); cfg_wr(3, frm);
    cfg_wr(4, l0); cfg_wr(5, l1);
    bmode = 3'(mode); bfmt = fmt[0]; bfrm = frm;
    bspace = 2 * ((ivl < 40) ? 40 : ivl);
    if (l0 != 0) blen[0] = (l0 > 16) ? 16 : l0;
    if (l1 != 0) blen[1] = (l1 > 16) ? 16 : l1;
  endtask

  task automatic go();
    @(negedge clk);
    bptr[0] = 0; bptr[1] = 0; wcnt = 0; last_rise = -1; last_u = 1;
    first_after_start = 1; nreq = 0; nwords = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt(input string tag);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (60 + lat) @(negedge clk);
    chk(nwords == nreq, tag, nwords, nreq);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    expq.delete(); hang = 0; blen[0] = 1; blen[1] = 1;
    chk(conv_req == 2'b00, "R11 no request after reset", conv_req, 0);
    chk(out_valid == 1'b0, "R11 no word after reset", out_valid, 0);
    chk(overrun == 1'b0, "R11 overrun clear after reset", overrun, 0);
    rst = 1'b0;
  endtask

  initial begin
    lat = 5; serial = 0; hang = 0; bmode = 3'd1; bfmt = 0; bfrm = 0; bspace = 80;
    blen[0] = 1; blen[1] = 1;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      tbl_m[0][i] = 8'((i << 4) | ((i % 4) << 2) | ((i + 1) % 4));
      tbl_m[1][i] = 8'(((15 - i) << 4) | (((i + 2) % 4) << 2) | ((i * 3) % 4));
      cfg_wr(16 + i, tbl_m[0][i]);
      cfg_wr(32 + i, tbl_m[1][i]);
    end

    // R2 R4 R5 R8: unit 1, short table, frame of 3
    setup(1, 0, 0, 40, 1, 3, 5, 1);
    go(); repeat (1000) @(negedge clk);
    chk(nreq >= 11 && nreq <= 13, "R4 trigger count in 1000 cycles", nreq, 12);
    halt("R5 every result delivered");

    // R2 R4 R6: unit 2, full table, zero length ignored, clamped interval
    setup(2, 1, 0, 10, 1, 0, 1, 16);
    cfg_wr(5, 0);
    go(); repeat (1500) @(negedge clk);
    chk(nreq >= 17, "R2 walk past table end", nreq, 18);
    halt("R6 every result delivered");

    // R3 R8 R12: both units together, frame of 4
    setup(3, 1, 0, 40, 1, 4, 3, 2);
    go(); repeat (800) @(negedge clk);
    chk(nreq >= 18, "R3 both units requested", nreq, 18);
    halt("R12 every result delivered");

    // R3 R4: alternating units, interval 50
    setup(7, 0, 0, 50, 1, 0, 4, 3);
    go(); repeat (1000) @(negedge clk);
    halt("R3 every result delivered");

    // R7: trigger limit of 4
    setup(1, 0, 1, 40, 4, 0, 16, 16);
    go(); repeat (800) @(negedge clk);
    chk(nreq == 4, "R7 limit stops triggering", nreq, 4);
    halt("R7 every result delivered");

    // R9: converter never answers
    setup(1, 0, 0, 40, 1, 0, 16, 16);
    hang = 1;
    go(); repeat (400) @(negedge clk);
    chk(nreq == 1, "R9 dropped triggers issue nothing", nreq, 1);
    chk(overrun == 1'b1, "R9 overrun raised", overrun, 1);
    repeat (100) @(negedge clk);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    do_reset();

    // R10: stop while a conversion is in flight
    setup(1, 0, 0, 40, 1, 0, 16, 16);
    lat = 30;
    go();
    while (nreq == 0) @(negedge clk);
    repeat (2) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (400) @(negedge clk);
    chk(nreq == 1, "R10 no trigger after stop", nreq, 1);
    chk(nwords == 1, "R10 in-flight word delivered", nwords, 1);
    lat = 5;

    // R3: unused mode code issues nothing
    setup(4, 0, 0, 40, 1, 0, 16, 16);
    go(); repeat (300) @(negedge clk);
    chk(nreq == 0, "R3 unused mode silent", nreq, 0);
    chk(out_valid == 1'b0, "R3 unused mode no word", out_valid, 0);
    halt("R3 nothing pending");

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog R11: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule